// File: doc/BRIEF.md
# Chained Transmit Descriptor DMA

This block pulls transmit data for a serial framer out of a shared memory that is organised as a chain of descriptors. Each descriptor names a data buffer, its length, a set of per-buffer flags and the address of the following descriptor. The engine reads each buffer one 16-bit word at a time and hands its bytes, low byte first, to a downstream framer over a byte stream with a valid/ready handshake. Three sideband bits travel with each byte: the frame end marker, a request to spoil the frame check sequence, and a priority class select.

After each buffer the engine writes a status word back into the descriptor. It can raise an interrupt, and it then either follows the link to the next descriptor or parks until software sends a new start command. A descriptor flagged as a frame start also has its own address copied to a fixed record location. Software can then find where the current frame began.

A descriptor occupies six consecutive 16-bit words at byte offsets 0x0, 0x2, 0x4, 0x6, 0x8 and 0xA from its (even) address. Software fills the first five and the engine writes only the last.

Top module: `txdesc_dma`

## Requirements
- R1: After reset, and until the first start command, mem_req, tx_valid and irq are 0. A start command (cmd_start high for one cycle) is accepted when the engine is idle or parked, and it begins at cmd_addr with bit 0 forced to 0.
- R2: The word at offset 0x4 gives buffer address bits 15..0, with bit 0 forced to 0, and bits 7..0 of the word at 0x6 give address bits 23..16. Bytes go out in ascending address order, the low byte of each word first. When the count is odd, the high byte of the last word is dropped.
- R3: Bits 11..0 of the word at offset 0x2 give the byte count of the buffer, and the value 0 stands for 4096 bytes.
- R4: The control word at 0x0 has an end-of-frame flag in bit 13. tx_last is 1 on the final byte of a buffer whose end-of-frame flag is set, and it is 0 on every other byte. A buffer without the flag runs on into the next descriptor's buffer as part of the same frame.
- R5: tx_crcbad is 1 only together with tx_last, and only when bit 9 of the control word (corrupt-check flag) is set. tx_pri equals bit 8 of the control word on every byte of that buffer.
- R6: When bit 14 of the control word (frame-start flag) is set, the engine writes the descriptor address into the record location before it sends any data. Address bits 15..0 go to REC_ADDR and bits 23..16 go to REC_ADDR+2. When the flag is clear, neither word is written.
- R7: After the last byte of a buffer has been accepted, the engine writes the status word to offset 0xA. Bit 15 is 1, bit 13 is the underrun flag, and all other bits are 0.
- R8: The underrun flag (status bit 13) is set when, in the middle of a frame, a buffer word read has been waiting for LATE_LIM cycles or more.
- R9: After each status write, irq pulses for exactly one cycle if bit 15 (interrupt request flag) or bit 12 (end-of-queue flag) of the control word is set. In that cycle irq_cause bit 0 equals bit 15 and irq_cause bit 1 equals bit 12. When both flags are clear, there is no pulse.
- R10: After the status write of a descriptor with the end-of-queue flag set, the engine parks. It makes no memory access and sends no byte until a start command resumes it at the new address.
- R11: When the end-of-queue flag is clear, the engine continues with the descriptor whose address is built from bits 7..0 of the control word (bits 23..16) and the word at 0x8 (bits 15..0, bit 0 forced to 0).
- R12: A start command that arrives while the engine is working is ignored.
- R13: While tx_valid is 1 and tx_ready is 0, tx_valid, tx_data and the three sideband outputs hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_start | input | 1 | Start command pulse |
| cmd_addr | input | 24 | First descriptor address for a start command |
| mem_req | output | 1 | Memory access request, held until acknowledged |
| mem_we | output | 1 | 1 for a write, 0 for a read |
| mem_addr | output | 24 | Byte address of the 16-bit word |
| mem_wdata | output | 16 | Write data |
| mem_ack | input | 1 | One-cycle acknowledge; read data is valid with it |
| mem_rdata | input | 16 | Read data |
| tx_valid | output | 1 | Byte available |
| tx_ready | input | 1 | Downstream accepts the byte |
| tx_data | output | 8 | Byte to transmit |
| tx_last | output | 1 | Final byte of a frame |
| tx_crcbad | output | 1 | Spoil the check sequence of this frame |
| tx_pri | output | 1 | Priority class select |
| irq | output | 1 | One-cycle interrupt pulse |
| irq_cause | output | 2 | Bit 0: buffer/frame done, bit 1: end of queue |

## Verification
Most internal errors in this engine show up as wrong memory traffic, and they show it fast. If a pointer is latched into the wrong register, the very next read goes to a wrong address, and the scoreboard sees the byte stream go wrong at the first byte of that buffer. A wrong remaining-byte count shows up as a wrong frame end marker or an extra or missing byte at the end of the buffer. A state machine that fails to park or to reject a start command shows up as memory requests or bytes during a quiet window, or as a stream that departs from the expected chain. Status and record faults are visible only in memory, so the bench reads back those words once each chain has parked.

// File: rtl/txd_pkg.sv
package txd_pkg;

  typedef enum logic [3:0] {
    S_IDLE, S_F0, S_F1, S_F2, S_F3, S_F4,
    S_REC0, S_REC1, S_XFER, S_WRST, S_NEXT, S_HALT
  } txd_state_e;

  // byte offsets inside one descriptor
  localparam int OFS_CTRL = 0;
  localparam int OFS_CNT  = 2;
  localparam int OFS_BLO  = 4;
  localparam int OFS_BHI  = 6;
  localparam int OFS_NLO  = 8;
  localparam int OFS_STAT = 10;

  // control word bit positions
  localparam int CB_INT  = 15;
  localparam int CB_SOF  = 14;
  localparam int CB_EOF  = 13;
  localparam int CB_EOQ  = 12;
  localparam int CB_CRC  = 9;
  localparam int CB_PRI  = 8;

  typedef struct packed {
    logic last;
    logic crcbad;
    logic pri;
  } txd_side_t;

endpackage

// File: rtl/txd_late.sv
module txd_late #(
  parameter int LATE_LIM = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic waiting,
  output logic und
);
  localparam int CW = $clog2(LATE_LIM + 1);

  logic [CW-1:0] cnt_q;
  logic          und_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      und_q <= 1'b0;
    end else begin
      if (clr) und_q <= 1'b0;
      if (!waiting) begin
        cnt_q <= '0;
      end else if (cnt_q == CW'(LATE_LIM - 1)) begin
        und_q <= 1'b1;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign und = und_q;

  // R8: once flagged, the underrun stays until the next descriptor fetch
  assert_und_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    (und_q && !clr) |=> und_q)
    else $error("underrun flag dropped mid-descriptor");

endmodule

// File: rtl/txd_pump.sv
module txd_pump
  import txd_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        load,
  input  logic        two,
  input  logic [15:0] wd,
  input  txd_side_t   side_lo,
  input  txd_side_t   side_hi,
  output logic        empty,
  output logic        frame_open,
  input  logic        tx_ready,
  output logic        tx_valid,
  output logic [7:0]  tx_data,
  output logic        tx_last,
  output logic        tx_crcbad,
  output logic        tx_pri
);
  logic       v_q, hv_q, open_q;
  logic [7:0] d_q, hd_q;
  txd_side_t  s_q, hs_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      v_q    <= 1'b0;
      hv_q   <= 1'b0;
      open_q <= 1'b0;
      d_q    <= '0;
      hd_q   <= '0;
      s_q    <= '0;
      hs_q   <= '0;
    end else begin
      if (load) begin
        v_q  <= 1'b1;
        d_q  <= wd[7:0];
        s_q  <= side_lo;
        hv_q <= two;
        hd_q <= wd[15:8];
        hs_q <= side_hi;
      end else if (v_q && tx_ready) begin
        if (hv_q) begin
          d_q  <= hd_q;
          s_q  <= hs_q;
          hv_q <= 1'b0;
        end else begin
          v_q <= 1'b0;
        end
      end
      if (v_q && tx_ready) open_q <= !s_q.last;
    end
  end

  assign empty      = !v_q && !hv_q;
  assign frame_open = open_q;
  assign tx_valid   = v_q;
  assign tx_data    = d_q;
  assign tx_last    = s_q.last;
  assign tx_crcbad  = s_q.crcbad;
  assign tx_pri     = s_q.pri;

  // R13: a stalled byte and its sideband do not move
  assert_hold_R13: assert property (@(posedge clk) disable iff (rst)
    (v_q && !tx_ready) |=> (v_q && $stable(d_q) && $stable(s_q)))
    else $error("stalled byte changed");

  // R2: a word is only taken when nothing is left from the previous one
  assert_load_empty_R2: assert property (@(posedge clk) disable iff (rst)
    load |-> (!v_q && !hv_q))
    else $error("word loaded over pending bytes");

  // R5: spoiled-check request only on a frame end byte
  assert_crc_last_R5: assert property (@(posedge clk) disable iff (rst)
    (v_q && s_q.crcbad) |-> s_q.last)
    else $error("crcbad without last");

endmodule

// File: rtl/txdesc_dma.sv
module txdesc_dma
  import txd_pkg::*;
#(
  parameter int          AW       = 24,
  parameter int          CNTW     = 12,
  parameter int          LATE_LIM = 8,
  parameter logic [23:0] REC_ADDR = 24'h000100
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cmd_start,
  input  logic [AW-1:0] cmd_addr,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [15:0]   mem_wdata,
  input  logic          mem_ack,
  input  logic [15:0]   mem_rdata,
  output logic          tx_valid,
  input  logic          tx_ready,
  output logic [7:0]    tx_data,
  output logic          tx_last,
  output logic          tx_crcbad,
  output logic          tx_pri,
  output logic          irq,
  output logic [1:0]    irq_cause
);
  localparam int REMW = CNTW + 1;
  localparam int HIW  = AW - 16;
  localparam logic [REMW-1:0] MAXB = REMW'(1) << CNTW;
  localparam logic [AW-1:0]   EVEN = ~AW'(1);

  txd_state_e     st;
  logic [AW-1:0]  desc_q, ntda_q, ptr_q;
  logic [REMW-1:0] rem_q;
  logic           f_int, f_sof, f_eof, f_eoq, f_crc, f_pri;
  logic           req_q, we_q, irq_q;
  logic [AW-1:0]  addr_q;
  logic [15:0]    wdata_q;
  logic [1:0]     cause_q;

  logic           acc_on, acc_we;
  logic [AW-1:0]  acc_addr;
  logic [15:0]    acc_wd;

  logic           pump_empty, pump_open, pump_load, two, fin;
  logic           und;
  txd_side_t      side_lo, side_hi, side_fin;
  logic [15:0]    stat_w;

  assign two      = rem_q >= REMW'(2);
  assign fin      = rem_q <= REMW'(2);
  assign side_fin = '{last: fin && f_eof, crcbad: fin && f_eof && f_crc, pri: f_pri};
  assign side_lo  = two ? '{last: 1'b0, crcbad: 1'b0, pri: f_pri} : side_fin;
  assign side_hi  = side_fin;
  assign pump_load = (st == S_XFER) && req_q && mem_ack;
  assign stat_w   = {1'b1, 1'b0, und, 13'b0};

  // what the current state wants from memory
  always_comb begin
    acc_on   = 1'b0;
    acc_we   = 1'b0;
    acc_addr = desc_q;
    acc_wd   = '0;
    case (st)
      S_F0: begin acc_on = 1'b1; acc_addr = desc_q + AW'(OFS_CTRL); end
      S_F1: begin acc_on = 1'b1; acc_addr = desc_q + AW'(OFS_CNT);  end
      S_F2: begin acc_on = 1'b1; acc_addr = desc_q + AW'(OFS_BLO);  end
      S_F3: begin acc_on = 1'b1; acc_addr = desc_q + AW'(OFS_BHI);  end
      S_F4: begin acc_on = 1'b1; acc_addr = desc_q + AW'(OFS_NLO);  end
      S_REC0: begin
        acc_on = 1'b1; acc_we = 1'b1;
        acc_addr = AW'(REC_ADDR); acc_wd = desc_q[15:0];
      end
      S_REC1: begin
        acc_on = 1'b1; acc_we = 1'b1;
        acc_addr = AW'(REC_ADDR) + AW'(2); acc_wd = 16'(desc_q[AW-1:16]);
      end
      S_XFER: begin
        acc_on = (rem_q != '0) && pump_empty; acc_addr = ptr_q;
      end
      S_WRST: begin
        acc_on = 1'b1; acc_we = 1'b1;
        acc_addr = desc_q + AW'(OFS_STAT); acc_wd = stat_w;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= S_IDLE;
      desc_q  <= '0;
      ntda_q  <= '0;
      ptr_q   <= '0;
      rem_q   <= '0;
      {f_int, f_sof, f_eof, f_eoq, f_crc, f_pri} <= '0;
      req_q   <= 1'b0;
      we_q    <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
      irq_q   <= 1'b0;
      cause_q <= '0;
    end else begin
      irq_q <= 1'b0;
      if (req_q) begin
        if (mem_ack) begin
          req_q <= 1'b0;
          we_q  <= 1'b0;
          case (st)
            S_F0: begin
              f_int <= mem_rdata[CB_INT];
              f_sof <= mem_rdata[CB_SOF];
              f_eof <= mem_rdata[CB_EOF];
              f_eoq <= mem_rdata[CB_EOQ];
              f_crc <= mem_rdata[CB_CRC];
              f_pri <= mem_rdata[CB_PRI];
              ntda_q[AW-1:16] <= mem_rdata[HIW-1:0];
              st <= S_F1;
            end
            S_F1: begin
              rem_q <= (mem_rdata[CNTW-1:0] == '0) ? MAXB : REMW'(mem_rdata[CNTW-1:0]);
              st <= S_F2;
            end
            S_F2: begin ptr_q[15:0] <= mem_rdata & 16'hFFFE; st <= S_F3; end
            S_F3: begin ptr_q[AW-1:16] <= mem_rdata[HIW-1:0]; st <= S_F4; end
            S_F4: begin
              ntda_q[15:0] <= mem_rdata & 16'hFFFE;
              st <= f_sof ? S_REC0 : S_XFER;
            end
            S_REC0: st <= S_REC1;
            S_REC1: st <= S_XFER;
            S_XFER: begin
              ptr_q <= ptr_q + AW'(2);
              rem_q <= rem_q - (two ? REMW'(2) : REMW'(1));
            end
            S_WRST: begin
              irq_q   <= f_int | f_eoq;
              cause_q <= {f_eoq, f_int};
              st      <= f_eoq ? S_HALT : S_NEXT;
            end
            default: ;
          endcase
        end
      end else if (acc_on) begin
        req_q   <= 1'b1;
        we_q    <= acc_we;
        addr_q  <= acc_addr;
        wdata_q <= acc_wd;
      end else begin
        case (st)
          S_IDLE, S_HALT: if (cmd_start) begin
            desc_q <= cmd_addr & EVEN;
            st     <= S_F0;
          end
          S_XFER: if (rem_q == '0 && pump_empty) st <= S_WRST;
          S_NEXT: begin desc_q <= ntda_q; st <= S_F0; end
          default: ;
        endcase
      end
    end
  end

  txd_pump u_pump (
    .clk(clk), .rst(rst), .load(pump_load), .two(two), .wd(mem_rdata),
    .side_lo(side_lo), .side_hi(side_hi), .empty(pump_empty), .frame_open(pump_open),
    .tx_ready(tx_ready), .tx_valid(tx_valid), .tx_data(tx_data), .tx_last(tx_last),
    .tx_crcbad(tx_crcbad), .tx_pri(tx_pri)
  );

  txd_late #(.LATE_LIM(LATE_LIM)) u_late (
    .clk(clk), .rst(rst), .clr(st == S_F0),
    .waiting((st == S_XFER) && req_q && pump_open), .und(und)
  );

  assign mem_req   = req_q;
  assign mem_we    = we_q;
  assign mem_addr  = addr_q;
  assign mem_wdata = wdata_q;
  assign irq       = irq_q;
  assign irq_cause = cause_q;

  // R2: an access is held steady until it is acknowledged
  assert_memhold_R2: assert property (@(posedge clk) disable iff (rst)
    (req_q && !mem_ack) |=> (req_q && $stable(addr_q) && $stable(we_q) && $stable(wdata_q)))
    else $error("memory request changed before ack");

  // R9: interrupt is a single-cycle pulse
  assert_irq_pulse_R9: assert property (@(posedge clk) disable iff (rst)
    irq_q |=> !irq_q)
    else $error("irq longer than one cycle");

  // R10: parked engine stays off the memory
  assert_halt_quiet_R10: assert property (@(posedge clk) disable iff (rst)
    (st == S_HALT) |-> !req_q)
    else $error("memory access while parked");

endmodule

// File: tb/sim_txdesc_dma.sv
module sim_txdesc_dma;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cmd_start = 1'b0;
  logic [23:0] cmd_addr = '0;
  logic        mem_req, mem_we, mem_ack;
  logic [23:0] mem_addr;
  logic [15:0] mem_wdata, mem_rdata;
  logic        tx_valid, tx_ready, tx_last, tx_crcbad, tx_pri, irq;
  logic [7:0]  tx_data;
  logic [1:0]  irq_cause;

  logic [15:0] mem [0:16383];
  logic [10:0] expq [$];
  int          checks = 0;
  int          errors = 0;
  int          lat_buf = 1;
  int          lcnt = 0;
  int          rc = 0;
  logic        stall_p = 1'b0;
  logic [10:0] stall_v = '0;

  always #5 clk = ~clk;

  txdesc_dma u0 (
    .clk(clk), .rst(rst), .cmd_start(cmd_start), .cmd_addr(cmd_addr),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .tx_data(tx_data), .tx_last(tx_last), .tx_crcbad(tx_crcbad), .tx_pri(tx_pri),
    .irq(irq), .irq_cause(irq_cause)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  // memory responder
  initial begin
    mem_ack = 1'b0;
    mem_rdata = '0;
    forever begin
      @(posedge clk);
      if (mem_ack) begin
        mem_ack <= 1'b0;
        lcnt <= 0;
      end else if (mem_req) begin
        if (lcnt >= ((mem_addr >= 24'h001000) ? lat_buf : 1)) begin
          mem_ack <= 1'b1;
          if (mem_we) mem[mem_addr[14:1]] = mem_wdata;
          else mem_rdata <= mem[mem_addr[14:1]];
        end else begin
          lcnt <= lcnt + 1;
        end
      end
    end
  end

  // stream monitor: ready pattern, scoreboard, hold check
  initial begin
    tx_ready = 1'b0;
    forever begin
      @(negedge clk);
      rc++;
      if (stall_p)
        check(tx_valid && {tx_last, tx_crcbad, tx_pri, tx_data} == stall_v, "R13 hold",
              int'({tx_last, tx_crcbad, tx_pri, tx_data}), int'(stall_v));
      tx_ready = ((rc % 7) != 3) && ((rc % 11) != 5);
      stall_p = tx_valid && !tx_ready;
      stall_v = {tx_last, tx_crcbad, tx_pri, tx_data};
      if (tx_valid && tx_ready) begin
        if (expq.size() == 0) begin
          check(1'b0, "R2 unexpected byte", int'(tx_data), 0);
        end else begin
          logic [10:0] e;
          e = expq.pop_front();
          check({tx_last, tx_crcbad, tx_pri, tx_data} == e, "R2/R4/R5 byte+sideband",
                int'({tx_last, tx_crcbad, tx_pri, tx_data}), int'(e));
        end
      end
    end
  end

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual 0 expected 1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  // flags byte: 80 int, 40 start, 20 end, 10 eoq, 02 crc, 01 pri
  task automatic wr_desc(input int a, input logic [7:0] fl, input logic [11:0] cnt,
                         input logic [23:0] buf_a, input logic [23:0] nxt);
    mem[a/2]     = {fl, nxt[23:16]};
    mem[a/2 + 1] = {4'h0, cnt};
    mem[a/2 + 2] = buf_a[15:0];
    mem[a/2 + 3] = {8'h00, buf_a[23:16]};
    mem[a/2 + 4] = nxt[15:0];
    mem[a/2 + 5] = 16'h0000;
  endtask

  task automatic push_buf(input int buf_a, input int cnt, input bit eof, input bit crc, input bit pri);
    int n;
    n = (cnt == 0) ? 4096 : cnt;
    for (int k = 0; k < n; k++) begin
      int a;
      logic [15:0] w;
      logic lst;
      a = (buf_a & ~1) + k;
      w = mem[a / 2];
      lst = eof && (k == n - 1);
      expq.push_back({lst, lst && crc, pri, (a % 2 == 1) ? w[15:8] : w[7:0]});
    end
  endtask

  task automatic start(input logic [23:0] a);
    @(negedge clk);
    cmd_start = 1'b1;
    cmd_addr = a;
    @(negedge clk);
    cmd_start = 1'b0;
  endtask

  task automatic wait_irq(input logic [1:0] exp, input string req);
    int t;
    t = 0;
    do begin
      @(negedge clk);
      t++;
    end while (!irq && t < 40000);
    check(irq && irq_cause == exp, req, int'({irq, irq_cause}), int'({1'b1, exp}));
  endtask

  task automatic quiet(input int n, input string req);
    bit busy;
    busy = 1'b0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (mem_req || tx_valid || irq) busy = 1'b1;
    end
    check(!busy, req, int'(busy), 0);
  endtask

  initial begin
    for (int i = 0; i < 16384; i++) mem[i] = 16'(i * 40503 + 7);
    repeat (5) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1: reset state and idling without a command
    check(!mem_req && !tx_valid && !irq, "R1 reset outputs", int'({mem_req, tx_valid, irq}), 0);
    quiet(20, "R1 idle without start");

    // chain of three: odd counts, unaligned pointers, frame across buffers
    wr_desc(16'h0200, 8'hC1, 12'd5, 24'h001001, 24'h000221);
    wr_desc(16'h0220, 8'h23, 12'd4, 24'h001100, 24'h000240);
    wr_desc(16'h0240, 8'hF0, 12'd3, 24'h001200, 24'h000000);
    push_buf(32'h1001, 5, 1'b0, 1'b0, 1'b1);  // R2 odd count, bit0 forced
    push_buf(32'h1100, 4, 1'b1, 1'b1, 1'b1);  // R4 R5 R11 link with bit0 set
    push_buf(32'h1200, 3, 1'b1, 1'b0, 1'b0);
    start(24'h000200);
    while (!tx_valid) @(negedge clk);
    start(24'h000300);                         // R12 ignored while busy
    wait_irq(2'b01, "R9 cause buffer done");
    wait_irq(2'b11, "R9 R10 cause done+eoq");
    quiet(30, "R10 parked");
    check(expq.size() == 0, "R4 R12 all bytes seen", expq.size(), 0);
    check(mem[16'h0100/2] == 16'h0240 && mem[16'h0102/2] == 16'h0000, "R6 record written",
          int'(mem[16'h0100/2]), 16'h0240);
    check(mem[(16'h0200 + 10)/2] == 16'h8000, "R7 status d0", int'(mem[(16'h0200 + 10)/2]), 16'h8000);
    check(mem[(16'h0220 + 10)/2] == 16'h8000, "R7 status d1", int'(mem[(16'h0220 + 10)/2]), 16'h8000);
    check(mem[(16'h0240 + 10)/2] == 16'h8000, "R7 status d2", int'(mem[(16'h0240 + 10)/2]), 16'h8000);

    // count 0 means 4096, no start flag, resume from parked
    mem[16'h0100/2] = 16'hBEEF;
    mem[16'h0102/2] = 16'hBEEF;
    wr_desc(16'h0260, 8'h30, 12'd0, 24'h002000, 24'h000000);
    push_buf(32'h2000, 0, 1'b1, 1'b0, 1'b0);  // R3
    start(24'h000260);
    wait_irq(2'b10, "R9 R10 cause eoq only");
    quiet(10, "R10 parked again");
    check(expq.size() == 0, "R3 4096 bytes", expq.size(), 0);
    check(mem[16'h0100/2] == 16'hBEEF && mem[16'h0102/2] == 16'hBEEF, "R6 no record write",
          int'(mem[16'h0100/2]), 16'hBEEF);
    check(mem[(16'h0260 + 10)/2] == 16'h8000, "R7 status d3", int'(mem[(16'h0260 + 10)/2]), 16'h8000);

    // late buffer reads mid-frame
    lat_buf = 12;
    wr_desc(16'h0280, 8'hF0, 12'd6, 24'h001300, 24'h000000);
    push_buf(32'h1300, 6, 1'b1, 1'b0, 1'b0);
    start(24'h000280);
    wait_irq(2'b11, "R9 after underrun");
    quiet(10, "R10 parked after underrun");
    check(expq.size() == 0, "R8 bytes delivered", expq.size(), 0);
    check(mem[(16'h0280 + 10)/2] == 16'hA000, "R8 underrun status", int'(mem[(16'h0280 + 10)/2]), 16'hA000);
    check(mem[16'h0100/2] == 16'h0280, "R6 record d4", int'(mem[16'h0100/2]), 16'h0280);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule